// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of a dual-slope integrating analog-to-digital converter. It runs on the oscillator clock and divides it by four to get the integration clock. It then repeats a fixed measurement cycle, and each cycle has three phases. In offset-nulling (auto-zero) the analog front end cancels its own offsets. In signal integration the input is integrated for a fixed time. In reference de-integration a reference of the opposite polarity runs the integrator back to zero. The analog integrator, the comparator and the switches sit outside the block. The block drives one enable per phase and a reference-polarity select, and it watches the comparator.

The comparator level is synchronized and sampled on the tick that ends integration. That sampled level picks the reference direction and sets the sign of the result. During de-integration the block counts ticks in four BCD decades until the synchronized comparator level departs from the sampled one. The count then becomes the reading, which is proportional to 1000 × Vin/Vref. If no crossing arrives within the count limit, the block stops anyway and flags overrange. Any part of the de-integration budget left unused goes to the next offset-nulling phase, so a measurement always takes the same number of ticks.

Top module: `dslope_seq`

## Requirements
- R1: The phase sequencer advances only on an integration tick, which comes once every DIV (default 4) oscillator cycles, so every phase lasts a whole multiple of DIV oscillator cycles.
- R2: Exactly one of `az_en`, `int_en`, `deint_en` is high at any time, and the phases always run in the order offset-nulling, integration, de-integration, then offset-nulling again.
- R3: Integration lasts exactly INT_CNT ticks (default 1000), whatever the comparator does.
- R4: During de-integration the count starts at 0 and rises by one per tick. The phase ends on the first tick at which the synchronized comparator level differs from the level sampled at the end of integration. The reading is the count at that tick, from 0 to DEINT_MAX (default 1999).
- R5: If no crossing is seen by the tick at which the count equals DEINT_MAX, de-integration ends on that tick with reading DEINT_MAX and `ovr_out` = 1. Otherwise `ovr_out` = 0.
- R6: From one entry into de-integration to the next there are always CYCLE ticks (default 4000). The offset-nulling phase lasts CYCLE − INT_CNT − (ticks spent in the previous de-integration), which is between 1000 and 2999 ticks with the defaults.
- R7: `ref_neg` takes the synchronized comparator level on the tick that ends integration and holds it until the next such tick. `sign_out` is 1 (negative input) when that level was 0.
- R8: When de-integration ends, `bcd_out` takes the reading as DIGITS BCD digits, with the least significant digit in bits [3:0] and each digit 0 to 9. `sign_out` and `ovr_out` update on the same edge, and `done` is high for exactly one oscillator cycle. All three result outputs then hold until the next `done`.
- R9: The comparator passes through a two-flop synchronizer. A change applied between oscillator edges k and k+1 is seen by the sequencer at edge k+3, so a change one edge after a tick's preceding edge lands on the next tick.
- R10: Reset is synchronous and active low. It forces offset-nulling (`az_en` = 1, the other enables 0) and clears `bcd_out`, `sign_out`, `ovr_out`, `done` and `ref_neg`. The first offset-nulling phase after reset lasts CYCLE − INT_CNT − DEINT_MAX − 1 ticks.
- R11: Comparator activity outside de-integration ends no phase and changes no result output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_in | input | 1 | Comparator output, asynchronous (1 = integrator above zero) |
| az_en | output | 1 | Offset-nulling phase enable |
| int_en | output | 1 | Signal-integration phase enable |
| deint_en | output | 1 | Reference de-integration phase enable |
| ref_neg | output | 1 | Reference polarity select for de-integration |
| bcd_out | output | 4*DIGITS | Latched reading, BCD, least significant digit in bits [3:0] |
| sign_out | output | 1 | Latched sign, 1 = negative input |
| ovr_out | output | 1 | Latched overrange flag |
| done | output | 1 | One-cycle pulse when a new result is latched |

## Verification
Two situations are hard to bring about from the ports. One is a crossing on the very last permitted count, which must give reading DEINT_MAX without overrange. The other is a de-integration that runs out the whole window. The bench watches `deint_en` rise and counts oscillator cycles from there. It flips the comparator at the exact cycle that, after synchronization, lands on the chosen tick, or it never flips it. It also toggles the comparator at random during offset-nulling to show that nothing outside de-integration reacts.

// File: rtl/dslope_pkg.sv
// Shared types for the dual-slope sequencer.
package dslope_pkg;
    typedef enum logic [1:0] {
        PH_AZ  = 2'd0,
        PH_INT = 2'd1,
        PH_DE  = 2'd2
    } phase_t;
endpackage

// File: rtl/dslope_prescale.sv
// Integration-tick generator.
// Emits a one-cycle tick every DIV oscillator cycles.
// Assumes DIV >= 2. Reset is synchronous, active low.
module dslope_prescale #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);

    logic [DW-1:0] div_q;

    assign tick = (div_q == DIV_LAST);

    // Free-running modulo-DIV counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + DW'(1);
    end

    // Ticks never come back to back.
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/dslope_sync.sv
// Multi-flop synchronizer for the asynchronous comparator level.
// Assumes STAGES >= 2. Resets to 0.
module dslope_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d};
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/dslope_bcd_cnt.sv
// Cascaded decimal counter of DIGITS decades.
// clr has priority over inc. Each decade wraps 9 -> 0 and carries upward.
module dslope_bcd_cnt #(
    parameter int DIGITS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  inc,
    output logic [4*DIGITS-1:0]   value
);
    logic [DIGITS-1:0] carry;

    assign carry[0] = inc;

    for (genvar gi = 0; gi < DIGITS; gi++) begin : g_dec
        logic [3:0] dig_q;
        logic       at_nine;

        assign at_nine = (dig_q == 4'd9);

        if (gi < DIGITS - 1) begin : g_carry
            assign carry[gi+1] = carry[gi] && at_nine;
        end

        // One decade: clear, hold, or step with wrap.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)  dig_q <= 4'd0;
            else if (carry[gi]) dig_q <= at_nine ? 4'd0 : dig_q + 4'd1;
        end

        assign value[4*gi +: 4] = dig_q;

        // A decade never leaves the decimal range.
        p_digit_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
            dig_q <= 4'd9);
    end
endmodule

// File: rtl/dslope_seq.sv
// Dual-slope conversion sequencer (top).
// Runs offset-nulling, integration and de-integration on integration ticks.
// Latches the comparator polarity at the end of integration, counts
// de-integration ticks in BCD until a crossing or the limit, and hands any
// unused de-integration budget to the next offset-nulling phase.
// Assumes CYCLE > INT_CNT + DEINT_MAX + 1 and a DIGITS-wide BCD range that
// holds DEINT_MAX. Synchronous active-low reset.
module dslope_seq
    import dslope_pkg::*;
#(
    parameter int DIV         = 4,
    parameter int INT_CNT     = 1000,
    parameter int DEINT_MAX   = 1999,
    parameter int CYCLE       = 4000,
    parameter int DIGITS      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk_osc,
    input  logic                rst_n,
    input  logic                cmp_in,
    output logic                az_en,
    output logic                int_en,
    output logic                deint_en,
    output logic                ref_neg,
    output logic [4*DIGITS-1:0] bcd_out,
    output logic                sign_out,
    output logic                ovr_out,
    output logic                done
);
    localparam int CW = $clog2(CYCLE + 1);
    localparam logic [CW-1:0] AZ_FIRST = CW'(CYCLE - INT_CNT - DEINT_MAX - 1);
    localparam logic [CW-1:0] AZ_BASE  = CW'(CYCLE - INT_CNT - 1);
    localparam logic [CW-1:0] INT_LAST = CW'(INT_CNT - 1);
    localparam logic [CW-1:0] DE_LAST  = CW'(DEINT_MAX);

    logic                tick;
    logic                cmp_s;
    phase_t              phase_q;
    logic [CW-1:0]       pcnt_q;
    logic [CW-1:0]       az_len_q;
    logic                pol_q;
    logic [4*DIGITS-1:0] cnt_bcd;
    logic [4*DIGITS-1:0] result_q;
    logic                sign_q;
    logic                ovr_q;
    logic                done_q;
    logic                crossing;
    logic                de_last;
    logic                bcd_clr;
    logic                bcd_inc;

    dslope_prescale #(.DIV(DIV)) u_pre (
        .clk   (clk_osc),
        .rst_n (rst_n),
        .tick  (tick)
    );

    dslope_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk_osc),
        .rst_n (rst_n),
        .d     (cmp_in),
        .q     (cmp_s)
    );

    // Crossing and limit detection for the current de-integration tick.
    always_comb begin
        crossing = (phase_q == PH_DE) && (cmp_s != pol_q);
        de_last  = (pcnt_q == DE_LAST);
        bcd_clr  = tick && (phase_q == PH_INT) && (pcnt_q == INT_LAST);
        bcd_inc  = tick && (phase_q == PH_DE) && !crossing && !de_last;
    end

    dslope_bcd_cnt #(.DIGITS(DIGITS)) u_bcd (
        .clk   (clk_osc),
        .rst_n (rst_n),
        .clr   (bcd_clr),
        .inc   (bcd_inc),
        .value (cnt_bcd)
    );

    // Phase sequencer, polarity latch and result capture.
    always_ff @(posedge clk_osc) begin
        if (!rst_n) begin
            phase_q  <= PH_AZ;
            pcnt_q   <= '0;
            az_len_q <= AZ_FIRST;
            pol_q    <= 1'b0;
            result_q <= '0;
            sign_q   <= 1'b0;
            ovr_q    <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (tick) begin
                unique case (phase_q)
                    PH_AZ: begin
                        if (pcnt_q == az_len_q - CW'(1)) begin
                            phase_q <= PH_INT;
                            pcnt_q  <= '0;
                        end else begin
                            pcnt_q  <= pcnt_q + CW'(1);
                        end
                    end
                    PH_INT: begin
                        if (pcnt_q == INT_LAST) begin
                            phase_q <= PH_DE;
                            pcnt_q  <= '0;
                            pol_q   <= cmp_s;
                        end else begin
                            pcnt_q  <= pcnt_q + CW'(1);
                        end
                    end
                    PH_DE: begin
                        if (crossing || de_last) begin
                            phase_q  <= PH_AZ;
                            pcnt_q   <= '0;
                            az_len_q <= AZ_BASE - pcnt_q;
                            result_q <= cnt_bcd;
                            sign_q   <= ~pol_q;
                            ovr_q    <= ~crossing;
                            done_q   <= 1'b1;
                        end else begin
                            pcnt_q   <= pcnt_q + CW'(1);
                        end
                    end
                    default: begin
                        phase_q <= PH_AZ;
                        pcnt_q  <= '0;
                    end
                endcase
            end
        end
    end

    assign az_en    = (phase_q == PH_AZ);
    assign int_en   = (phase_q == PH_INT);
    assign deint_en = (phase_q == PH_DE);
    assign ref_neg  = pol_q;
    assign bcd_out  = result_q;
    assign sign_out = sign_q;
    assign ovr_out  = ovr_q;
    assign done     = done_q;

    // Integration is always followed by de-integration.
    p_int_then_de_r2: assert property (@(posedge clk_osc) disable iff (!rst_n)
        $fell(int_en) |-> deint_en);

    // De-integration is always followed by offset-nulling.
    p_de_then_az_r2: assert property (@(posedge clk_osc) disable iff (!rst_n)
        $fell(deint_en) |-> az_en);

    // The de-integration counter never passes its limit.
    p_de_bound_r5: assert property (@(posedge clk_osc) disable iff (!rst_n)
        deint_en |-> (pcnt_q <= DE_LAST));

    // Reference polarity holds throughout de-integration.
    p_ref_hold_r7: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (deint_en && $past(deint_en)) |-> $stable(ref_neg));

    // The completion strobe lasts one cycle.
    p_done_pulse_r8: assert property (@(posedge clk_osc) disable iff (!rst_n)
        done |=> !done);

    // Results change only together with the strobe.
    p_result_hold_r8: assert property (@(posedge clk_osc) disable iff (!rst_n)
        !done |-> $stable(bcd_out));
endmodule

// File: tb/dslope_seq_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: scaled timing, directed corner readings mixed with
// seeded random readings and polarities, comparator noise in offset-nulling.
module dslope_seq_tb_top;
    localparam int DIV       = 4;
    localparam int INT_CNT   = 100;
    localparam int DEINT_MAX = 199;
    localparam int CYCLE     = 400;
    localparam int DIGITS    = 4;
    localparam int AZ_FIRST  = CYCLE - INT_CNT - DEINT_MAX - 1;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                cmp = 1'b0;
    logic                az_en, int_en, deint_en, ref_neg;
    logic [4*DIGITS-1:0] bcd;
    logic                sign_o, ovr_o, done;

    int checks = 0;
    int errors = 0;
    int pos_cnt = 0;
    int prev_rise = 0;
    bit have_prev = 0;

    always #2 clk = ~clk;

    dslope_seq #(
        .DIV(DIV), .INT_CNT(INT_CNT), .DEINT_MAX(DEINT_MAX),
        .CYCLE(CYCLE), .DIGITS(DIGITS), .SYNC_STAGES(2)
    ) dut_i (
        .clk_osc(clk), .rst_n(rst_n), .cmp_in(cmp),
        .az_en(az_en), .int_en(int_en), .deint_en(deint_en),
        .ref_neg(ref_neg), .bcd_out(bcd), .sign_out(sign_o),
        .ovr_out(ovr_o), .done(done)
    );

    // Edge counter and watchdog.
    always @(posedge clk) begin
        pos_cnt <= pos_cnt + 1;
        if (pos_cnt > 150000) begin
            errors = errors + 1;
            $display("FAIL R2 watchdog: actual %0d cycles, expected completion", pos_cnt);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [4*DIGITS-1:0] to_bcd(input int v);
        logic [4*DIGITS-1:0] r;
        int x;
        r = '0;
        x = v;
        for (int i = 0; i < DIGITS; i++) begin
            r[4*i +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%0h, expected 0x%0h", req, act, exp);
        end
    endtask

    // Reset, check the reset state, then time the first offset-nulling phase.
    task automatic do_reset();
        int cnt;
        rst_n = 1'b0;
        cmp = 1'b0;
        repeat (3) @(negedge clk);
        check(az_en && !int_en && !deint_en, "R10 enables", {az_en, int_en, deint_en}, 3'b100);
        check(bcd == '0 && !sign_o && !ovr_o && !done && !ref_neg, "R10 outputs",
              {bcd, sign_o, ovr_o, done, ref_neg}, 0);
        rst_n = 1'b1;
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (!int_en);
        check(cnt == DIV * AZ_FIRST, "R10 first offset-nulling length", cnt, DIV * AZ_FIRST);
        have_prev = 0;
    endtask

    // One conversion, entered at the negedge where int_en is first seen.
    // rd < 0 requests an overrange (comparator never crosses).
    task automatic convert(input int rd, input bit p);
        int cnt, spent, exp_rd, exp_idx;
        bit ovr, early;
        logic [4*DIGITS-1:0] held;
        logic held_s;
        ovr = (rd < 0);
        cmp = p;
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (!deint_en);
        check(cnt == DIV * INT_CNT, "R3 R1 integration length", cnt, DIV * INT_CNT);
        check(!az_en && !int_en, "R2 single phase enable", {az_en, int_en}, 0);
        check(ref_neg == p, "R7 reference polarity", ref_neg, p);
        if (have_prev)
            check(pos_cnt - prev_rise == DIV * CYCLE, "R6 cycle length",
                  pos_cnt - prev_rise, DIV * CYCLE);
        prev_rise = pos_cnt;
        have_prev = 1;
        early = 0;
        cnt = 0;
        if (!ovr) begin
            // R9: flip one edge after entry-relative tick boundary.
            repeat (DIV * rd + 1) begin
                @(negedge clk);
                cnt++;
                if (done) early = 1;
            end
            cmp = ~p;
        end
        while (!done) begin
            @(negedge clk);
            cnt++;
        end
        exp_rd  = ovr ? DEINT_MAX : rd;
        spent   = exp_rd + 1;
        exp_idx = DIV * spent;
        check(!early && cnt == exp_idx, "R4 R9 de-integration end cycle", cnt, exp_idx);
        check(bcd == to_bcd(exp_rd), ovr ? "R5 overrange reading" : "R4 R8 BCD reading",
              bcd, to_bcd(exp_rd));
        check(sign_o == ~p, "R7 sign", sign_o, ~p);
        check(ovr_o == ovr, "R5 overrange flag", ovr_o, ovr);
        held = bcd;
        held_s = sign_o;
        @(negedge clk);
        check(!done && az_en, "R8 R2 one-cycle done then offset-nulling", {done, az_en}, 2'b01);
        cnt = 1;
        while (!int_en) begin
            if ($urandom_range(0, 5) == 0) cmp = ~cmp;
            @(negedge clk);
            cnt++;
        end
        check(cnt == DIV * (CYCLE - INT_CNT - spent), "R6 offset-nulling length",
              cnt, DIV * (CYCLE - INT_CNT - spent));
        check(bcd == held && sign_o == held_s, "R11 R8 results held", {bcd, sign_o}, {held, held_s});
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        do_reset();
        convert(0, 1'b1);
        convert(1, 1'b0);
        convert(9, 1'b1);
        convert(10, 1'b0);
        convert(99, 1'b1);
        convert(100, 1'b0);
        convert(DEINT_MAX, 1'b1);
        convert(DEINT_MAX - 1, 1'b0);
        convert(-1, 1'b1);
        convert(-1, 1'b0);
        convert(3, 1'b1);
        for (int k = 0; k < 10; k++)
            convert(int'($urandom_range(0, DEINT_MAX)), 1'($urandom_range(0, 1)));
        // Reset in the middle of de-integration.
        cmp = 1'b1;
        while (!deint_en) @(negedge clk);
        repeat (7) @(negedge clk);
        do_reset();
        convert(42, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule